// File: doc/BRIEF.md
# Grouped Interrupt Capture Controller

This block collects single-cycle event pulses from four interrupt groups: hardware, bus controller, bus monitor and remote terminal. It turns them into one active-high host interrupt line. Each group has three host registers. A capture mask picks which event lines may be stored. A pending word holds the stored events until the host clears them. A second mask, the IRQ mask, picks which stored events may raise the host line. Because an event on a masked-off line is never stored, turning its capture bit on later cannot bring up a stale event.

The block also keeps a read-only status word. It holds two failure flags from the auto-initialization engine and two bus-inhibit flags, one for each remote terminal. The failure inputs count only when the auto-init strap was high on the first clock after master reset is released. A failure that counts also raises its own bit in the hardware group's pending word. The inhibit flags follow shutdown and override command pulses, and the host can also clear them with per-terminal soft-reset bits in a status write. Register access is a plain synchronous write port with a combinational read port.

Top module: `irq_capture_ctrl`

## Requirements
- R1: Group g (0 hardware, 1 bus controller, 2 bus monitor, 3 remote terminal) has its capture mask at word address 3g, its pending word at 3g+1 and its IRQ mask at 3g+2. The status word is at address 12. The capture mask and IRQ mask read back the last value written. Every address from 13 to 15 reads as 0.
- R2: On a clock where event line b of a group pulses, the pending bit b is set only if capture mask bit b is 1. An event on a line whose capture bit is 0 is dropped and leaves no trace.
- R3: Writing a word to a pending address clears each pending bit where the written word has a 1 (write-1-to-clear). If a captured event on the same bit arrives in the same clock, the bit stays set.
- R4: Clearing a capture mask bit leaves an already-pending bit set. It stops new captures on that bit and removes the bit's effect on the IRQ line.
- R5: irqOut is a register. It is high in the cycle after any group has some bit where pending, capture mask and IRQ mask are all 1. A pending, capture-enabled bit whose IRQ mask bit is 0 keeps irqOut low.
- R6: The strap is sampled on the first clock after reset release. If it was high, a checksum-failure pulse sets status bit 1 and hardware pending bit 14, and a verify-failure pulse sets status bit 0 and hardware pending bit 13. The pending bits are set only when their capture bits are 1. The status bits are set regardless of the capture mask.
- R7: If the strap was low at that sample, both failure pulses are ignored: they change no status bit and no pending bit.
- R8: Status bit 2 (terminal 1) and bit 3 (terminal 2) are set by that terminal's shutdown pulse. Each is cleared by that terminal's override pulse, or by a status write with bit 4 (terminal 1) or bit 5 (terminal 2) set. When a set and a clear arrive together, the clear wins.
- R9: Every register and status bit is 0 after reset. A host write to status bits 0 to 3 has no effect. Status bits 4 to 5 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Master reset, active low, asynchronous |
| autoInitStrap | input | 1 | Auto-init strap, sampled on the first clock after reset |
| regAddr | input | 4 | Register word address |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for regAddr (combinational) |
| evtIn | input | 64 | Event pulses, group g at bits [16g+15:16g] |
| eepromCsumFail | input | 1 | Checksum-failure pulse |
| ramVerifyFail | input | 1 | RAM verify-failure pulse |
| rt1ShutdownCmd | input | 1 | Terminal 1 shutdown command pulse |
| rt2ShutdownCmd | input | 1 | Terminal 2 shutdown command pulse |
| rt1OverrideCmd | input | 1 | Terminal 1 override command pulse |
| rt2OverrideCmd | input | 1 | Terminal 2 override command pulse |
| irqOut | output | 1 | Host interrupt, active high, registered |

## Verification
Several rules are checked on every cycle by the assertions:
- No pending bit rises without its capture bit set.
- A cleared bit with no qualifying event drops.
- An active bit raises irqOut on the next cycle.
- Failure flags never rise while the strap sample is low.
- Inhibit flags rise only after a shutdown pulse.
- At most one kind of register write happens at a time.

Other behaviours need the bench's scenarios. These are read-back through the address map, an event and a clear in the same cycle, and a pending bit that outlives its capture bit. They also include IRQ gating by the IRQ mask alone, the soft-reset clears and the second reset with the strap low. The bench compares these against its behavioural model.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int GROUP_CNT = 4;
  localparam int WORD_W = 16;
  localparam int GRP_IDX_W = $clog2(GROUP_CNT);
  localparam int EE_PEND_BIT = 14;
  localparam int RAM_PEND_BIT = 13;
  localparam int ST_RAM = 0;
  localparam int ST_EE = 1;
  localparam int ST_INH1 = 2;
  localparam int ST_INH2 = 3;
  localparam int ST_SOFT1 = 4;
  localparam int ST_SOFT2 = 5;
  localparam int STAT_ADDR = 3 * GROUP_CNT;

  typedef enum logic [2:0] {
    RD_NONE, RD_EN, RD_PEND, RD_OE, RD_STAT
  } rdKind_e;

  typedef struct packed {
    logic [GROUP_CNT-1:0] enWr;
    logic [GROUP_CNT-1:0] clrWr;
    logic [GROUP_CNT-1:0] oeWr;
    logic                 statWr;
    rdKind_e              rdKind;
    logic [GRP_IDX_W-1:0] rdGrp;
  } ctrlStrobes_t;
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output ctrlStrobes_t      strobes
);
  always_comb begin
    strobes = '0;
    strobes.rdKind = RD_NONE;
    for (int g = 0; g < GROUP_CNT; g++) begin
      if (int'(regAddr) == 3 * g) begin
        strobes.enWr[g] = regWrEn;
        strobes.rdKind = RD_EN;
        strobes.rdGrp = GRP_IDX_W'(g);
      end
      if (int'(regAddr) == 3 * g + 1) begin
        strobes.clrWr[g] = regWrEn;
        strobes.rdKind = RD_PEND;
        strobes.rdGrp = GRP_IDX_W'(g);
      end
      if (int'(regAddr) == 3 * g + 2) begin
        strobes.oeWr[g] = regWrEn;
        strobes.rdKind = RD_OE;
        strobes.rdGrp = GRP_IDX_W'(g);
      end
    end
    if (int'(regAddr) == STAT_ADDR) begin
      strobes.statWr = regWrEn;
      strobes.rdKind = RD_STAT;
    end
  end

  // R1
  single_write_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({|strobes.enWr, |strobes.clrWr, |strobes.oeWr, strobes.statWr}));
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobes_t                strobes,
  input  logic [WORD_W-1:0]           wrData,
  input  logic [GROUP_CNT*WORD_W-1:0] evtIn,
  input  logic                        autoInitStrap,
  input  logic                        eeFail,
  input  logic                        ramFail,
  input  logic                        sd1,
  input  logic                        sd2,
  input  logic                        ov1,
  input  logic                        ov2,
  output logic [WORD_W-1:0]           rdData,
  output logic                        irqOut
);
  logic [WORD_W-1:0] enQ   [GROUP_CNT];
  logic [WORD_W-1:0] pendQ [GROUP_CNT];
  logic [WORD_W-1:0] oeQ   [GROUP_CNT];
  logic [WORD_W-1:0] qualEvt [GROUP_CNT];
  logic [WORD_W-1:0] clrMask [GROUP_CNT];
  logic [GROUP_CNT-1:0] grpActive;
  logic strapQ, resetDoneQ, eeFlagQ, ramFlagQ, inh1Q, inh2Q, irqQ;
  logic eeQual, ramQual, soft1, soft2;

  assign eeQual  = eeFail & strapQ;
  assign ramQual = ramFail & strapQ;
  assign soft1   = strobes.statWr & wrData[ST_SOFT1];
  assign soft2   = strobes.statWr & wrData[ST_SOFT2];

  for (genvar g = 0; g < GROUP_CNT; g++) begin : gGrp
    if (g == 0) begin : gHw
      always_comb begin
        qualEvt[g] = evtIn[g*WORD_W +: WORD_W];
        qualEvt[g][EE_PEND_BIT]  = qualEvt[g][EE_PEND_BIT] | eeQual;
        qualEvt[g][RAM_PEND_BIT] = qualEvt[g][RAM_PEND_BIT] | ramQual;
      end
    end else begin : gOther
      assign qualEvt[g] = evtIn[g*WORD_W +: WORD_W];
    end

    assign clrMask[g]   = strobes.clrWr[g] ? wrData : '0;
    assign grpActive[g] = |(pendQ[g] & enQ[g] & oeQ[g]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enQ[g]   <= '0;
        pendQ[g] <= '0;
        oeQ[g]   <= '0;
      end else begin
        pendQ[g] <= (pendQ[g] & ~clrMask[g]) | (qualEvt[g] & enQ[g]);
        if (strobes.enWr[g]) enQ[g] <= wrData;
        if (strobes.oeWr[g]) oeQ[g] <= wrData;
      end
    end

    // R2
    no_masked_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pendQ[g] & ~$past(pendQ[g]) & ~$past(enQ[g])) == '0);
    // R3
    clear_takes_effect_chk: assert property (@(posedge clk) disable iff (!rstN)
      (pendQ[g] & $past(clrMask[g] & ~(qualEvt[g] & enQ[g]))) == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resetDoneQ <= 1'b0;
      strapQ     <= 1'b0;
      eeFlagQ    <= 1'b0;
      ramFlagQ   <= 1'b0;
      inh1Q      <= 1'b0;
      inh2Q      <= 1'b0;
      irqQ       <= 1'b0;
    end else begin
      resetDoneQ <= 1'b1;
      if (!resetDoneQ) strapQ <= autoInitStrap;
      if (eeQual)  eeFlagQ  <= 1'b1;
      if (ramQual) ramFlagQ <= 1'b1;
      if (ov1 || soft1) inh1Q <= 1'b0;
      else if (sd1)     inh1Q <= 1'b1;
      if (ov2 || soft2) inh2Q <= 1'b0;
      else if (sd2)     inh2Q <= 1'b1;
      irqQ <= |grpActive;
    end
  end

  assign irqOut = irqQ;

  always_comb begin
    rdData = '0;
    unique case (strobes.rdKind)
      RD_EN:   rdData = enQ[strobes.rdGrp];
      RD_PEND: rdData = pendQ[strobes.rdGrp];
      RD_OE:   rdData = oeQ[strobes.rdGrp];
      RD_STAT: begin
        rdData[ST_RAM]  = ramFlagQ;
        rdData[ST_EE]   = eeFlagQ;
        rdData[ST_INH1] = inh1Q;
        rdData[ST_INH2] = inh2Q;
      end
      default: rdData = '0;
    endcase
  end

  // R5
  irq_follows_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|grpActive) |=> irqOut);
  // R7
  no_fail_without_strap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strapQ |=> !$rose(eeFlagQ) && !$rose(ramFlagQ));
  // R8
  inhibit_needs_shutdown_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inh1Q) |-> $past(sd1));
endmodule

// File: rtl/irq_capture_ctrl.sv
module irq_capture_ctrl
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        autoInitStrap,
  input  logic [ADDR_W-1:0]           regAddr,
  input  logic                        regWrEn,
  input  logic [WORD_W-1:0]           regWrData,
  output logic [WORD_W-1:0]           regRdData,
  input  logic [GROUP_CNT*WORD_W-1:0] evtIn,
  input  logic                        eepromCsumFail,
  input  logic                        ramVerifyFail,
  input  logic                        rt1ShutdownCmd,
  input  logic                        rt2ShutdownCmd,
  input  logic                        rt1OverrideCmd,
  input  logic                        rt2OverrideCmd,
  output logic                        irqOut
);
  ctrlStrobes_t strobes;

  irqc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn), .strobes(strobes)
  );

  irqc_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(regWrData), .evtIn(evtIn),
    .autoInitStrap(autoInitStrap), .eeFail(eepromCsumFail), .ramFail(ramVerifyFail),
    .sd1(rt1ShutdownCmd), .sd2(rt2ShutdownCmd), .ov1(rt1OverrideCmd), .ov2(rt2OverrideCmd),
    .rdData(regRdData), .irqOut(irqOut)
  );
endmodule

// File: tb/irq_capture_ctrl_bench.sv
module irq_capture_ctrl_bench;
  logic clk = 0, rstN = 0, strap = 1;
  logic [3:0] addr = 0;
  logic we = 0;
  logic [15:0] wd = 0;
  logic [15:0] rd;
  logic [63:0] evt = 0;
  logic ee = 0, ram = 0, sd1 = 0, sd2 = 0, ov1 = 0, ov2 = 0;
  logic irq;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  irq_capture_ctrl u_irq_capture_ctrl (
    .clk(clk), .rstN(rstN), .autoInitStrap(strap), .regAddr(addr), .regWrEn(we),
    .regWrData(wd), .regRdData(rd), .evtIn(evt), .eepromCsumFail(ee),
    .ramVerifyFail(ram), .rt1ShutdownCmd(sd1), .rt2ShutdownCmd(sd2),
    .rt1OverrideCmd(ov1), .rt2OverrideCmd(ov2), .irqOut(irq)
  );

  // behavioural reference model
  logic [15:0] mEn [4], mPend [4], mOe [4];
  logic mEeF, mRamF, mInh1, mInh2, mStrap, mDone, mIrq;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int g = 0; g < 4; g++) begin mEn[g] = 0; mPend[g] = 0; mOe[g] = 0; end
      {mEeF, mRamF, mInh1, mInh2, mStrap, mDone, mIrq} = 0;
    end else begin
      logic acc;
      logic [15:0] ev, clr;
      acc = 0;
      for (int g = 0; g < 4; g++) acc = acc | (|(mPend[g] & mEn[g] & mOe[g]));
      mIrq = acc;
      for (int g = 0; g < 4; g++) begin
        ev = evt[g*16 +: 16];
        if (g == 0 && mStrap) begin
          ev[14] = ev[14] | ee;
          ev[13] = ev[13] | ram;
        end
        clr = (we && addr == 4'(3*g+1)) ? wd : 16'h0;
        mPend[g] = (mPend[g] & ~clr) | (ev & mEn[g]);
        if (we && addr == 4'(3*g))   mEn[g] = wd;
        if (we && addr == 4'(3*g+2)) mOe[g] = wd;
      end
      if (mStrap && ee)  mEeF = 1;
      if (mStrap && ram) mRamF = 1;
      if (ov1 || (we && addr == 12 && wd[4])) mInh1 = 0; else if (sd1) mInh1 = 1;
      if (ov2 || (we && addr == 12 && wd[5])) mInh2 = 0; else if (sd2) mInh2 = 1;
      if (!mDone) begin mStrap = strap; mDone = 1; end
    end
  end

  function automatic logic [15:0] mRead(input int a);
    if (a < 12) begin
      case (a % 3)
        0: return mEn[a/3];
        1: return mPend[a/3];
        default: return mOe[a/3];
      endcase
    end
    if (a == 12) return {12'h0, mInh2, mInh1, mEeF, mRamF};
    return 16'h0;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // irqOut compared with the model on every clock
  always @(negedge clk) if (rstN) check("R5 irq", {15'h0, irq}, {15'h0, mIrq});

  task automatic rdChk(input int a, input string tag);
    @(negedge clk); we = 0; addr = 4'(a); #1;
    check(tag, rd, mRead(a));
  endtask

  task automatic rdLit(input int a, input logic [15:0] exp, input string tag);
    @(negedge clk); we = 0; addr = 4'(a); #1;
    check(tag, rd, exp);
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk); addr = 4'(a); wd = d; we = 1;
    @(negedge clk); we = 0; wd = 0;
  endtask

  task automatic evPulse(input int g, input logic [15:0] bits);
    @(negedge clk); evt[g*16 +: 16] = bits;
    @(negedge clk); evt = 0;
  endtask

  task automatic doReset(input logic s);
    @(negedge clk); rstN = 0; strap = s;
    repeat (3) @(negedge clk);
    rstN = 1;
    repeat (2) @(negedge clk);
    strap = ~s;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    doReset(1'b1);
    // R9 reset values
    for (int a = 0; a < 16; a++) rdLit(a, 16'h0, "R9 reset");

    // R1 map and read-back
    wr(3, 16'h00F0); wr(5, 16'h0F00); wr(9, 16'hA5A5);
    rdLit(3, 16'h00F0, "R1 bc enable"); rdLit(5, 16'h0F00, "R1 bc oe");
    rdLit(9, 16'hA5A5, "R1 rt enable"); rdLit(0, 16'h0, "R1 hw enable untouched");
    wr(13, 16'hFFFF); wr(15, 16'hFFFF);
    for (int a = 13; a < 16; a++) rdLit(a, 16'h0, "R1 unmapped");

    // R2 capture only where enabled
    evPulse(1, 16'h0F0F);
    rdLit(4, 16'h000F & 16'h00F0, "R2 disabled lines dropped");
    evPulse(1, 16'h0030);
    rdLit(4, 16'h0030, "R2 enabled capture");
    wr(3, 16'hFFFF);
    rdLit(4, 16'h0030, "R2 stale event not revived");

    // R5 gating by IRQ mask alone: bits 4,5 pending, oe=0x0F00
    repeat (2) @(negedge clk);
    check("R5 low when oe clear", {15'h0, irq}, 16'h0);
    wr(5, 16'h0010);
    @(negedge clk);
    check("R5 high with oe", {15'h0, irq}, 16'h1);

    // R4 clearing enable keeps pending, drops irq
    wr(3, 16'h0000);
    rdLit(4, 16'h0030, "R4 pending kept");
    @(negedge clk);
    check("R4 irq removed", {15'h0, irq}, 16'h0);
    wr(3, 16'hFFFF);

    // R3 write-1-to-clear, and event wins over clear
    wr(4, 16'h0010);
    rdLit(4, 16'h0020, "R3 w1c");
    @(negedge clk); addr = 4; wd = 16'h0020; we = 1; evt[16 +: 16] = 16'h0020;
    @(negedge clk); we = 0; wd = 0; evt = 0;
    rdLit(4, 16'h0020, "R3 event wins");
    wr(4, 16'hFFFF);
    rdLit(4, 16'h0000, "R3 full clear");

    // other groups independently
    wr(6, 16'h8001); wr(8, 16'h8001);
    evPulse(2, 16'hFFFF);
    rdLit(7, 16'h8001, "R2 mt capture");
    repeat (2) @(negedge clk);
    check("R5 mt irq", {15'h0, irq}, 16'h1);
    wr(7, 16'h8001);
    rdChk(10, "R2 rt pending");

    // R6 failure events with strap high
    wr(0, 16'h4000);
    @(negedge clk); ee = 1; ram = 1;
    @(negedge clk); ee = 0; ram = 0;
    rdLit(1, 16'h4000, "R6 hw pending ee only");
    rdLit(12, 16'h0003, "R6 status flags");

    // R8 inhibit flags
    @(negedge clk); sd1 = 1;
    @(negedge clk); sd1 = 0; sd2 = 1;
    @(negedge clk); sd2 = 0;
    rdLit(12, 16'h000F, "R8 both set");
    @(negedge clk); ov1 = 1; sd1 = 1;
    @(negedge clk); ov1 = 0; sd1 = 0;
    rdLit(12, 16'h000B, "R8 override wins");
    wr(12, 16'h0020);
    rdLit(12, 16'h0003, "R8 soft reset rt2");
    @(negedge clk); sd1 = 1;
    @(negedge clk); sd1 = 0;
    wr(12, 16'h0010);
    rdLit(12, 16'h0003, "R8 soft reset rt1");

    // R9 status read-only
    wr(12, 16'h000C);
    rdLit(12, 16'h0003, "R9 read-only");

    // R7 strap low: failures ignored
    doReset(1'b0);
    wr(0, 16'h6000); wr(2, 16'h6000);
    @(negedge clk); ee = 1; ram = 1;
    @(negedge clk); ee = 0; ram = 0;
    rdLit(1, 16'h0000, "R7 no pending");
    rdLit(12, 16'h0000, "R7 no flags");
    repeat (2) @(negedge clk);
    check("R7 irq low", {15'h0, irq}, 16'h0);
    for (int a = 0; a < 13; a++) rdChk(a, "R1 model sweep");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule